// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block derives the 16x-oversampling strobe that a serial transmitter and receiver use as their bit-timing reference. The reference clock is divided by a programmable amount made of an integer part and a fraction counted in steps of 1/64. The divisor is the reference frequency over sixteen times the baud rate. Its fractional field is that quotient's fractional part times 64, rounded to the nearest step. For example, a 4 MHz reference at 230400 baud gives an integer of 1 and a fraction of 5, an effective divisor of about 1.078.

A fraction cannot stretch a single period. The block therefore adds the fraction into a 6-bit accumulator once per tick period, and each carry out of that accumulator lengthens the period by one reference cycle. Seen as one packed 22-bit word, the integer sits above the 6 fraction bits.

Divisor writes take effect only at a period boundary, so the period in progress is never cut short. Clearing the enable stops the strobe at once and clears the accumulator. The carry pattern then starts afresh from zero on the next enable.

Top module: `frac_baud_gen`

## Requirements
- R1: While reset is asserted, and afterwards while `en` is low, `tick` stays low.
- R2: Each tick period lasts `div_int` or `div_int`+1 reference cycles. With `div_frac` = 0 every period is exactly `div_int` cycles.
- R3: Over any 64 consecutive tick periods the total reference-cycle count equals 64×`div_int` + `div_frac` exactly.
- R4: Counting periods from enable as n = 1, 2, ..., period n lasts `div_int` + floor(n·`div_frac`/64) − floor((n−1)·`div_frac`/64) cycles. The accumulator starts at 0 when the block is enabled.
- R5: With `div_int` = 1 and `div_frac` = 0, `tick` is high on every cycle.
- R6: A `div_int` of 0 is illegal. When it is seen at a period boundary, tick generation stops and no further tick appears while it remains 0. A period already running still completes.
- R7: Driving `en` low removes `tick` from the next cycle on and clears the fractional accumulator.
- R8: A divisor change in the middle of a period does not alter that period. It governs the period after the next tick.
- R9: When `div_int` ≥ 2, `tick` is high for exactly one cycle per period.
- R10: With `div_int` = 1 and `div_frac` = 5, 64 periods span 69 reference cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Enables tick generation; low clears the state |
| div_int | input | INT_W (16) | Integer part of the divisor |
| div_frac | input | FRAC_W (6) | Fractional part of the divisor in 1/64 steps |
| tick | output | 1 | 16x-oversampling strobe |

## Verification
The bench builds the block with `INT_W` = 4 and the 6-bit fraction left as it is, so the integer ranges over 1 to 15. This small width makes a near-exhaustive sweep affordable: all 64 fractions for each integer from 1 to 4, plus a few fractions at the top integer of 15. Every sweep case checks each of 64 intervals against the carry formula and checks their total against 64×integer + fraction. Directed cases cover a mid-period divisor write, a zero integer and an enable drop.

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  output logic              tick
);

  logic              running;
  logic [INT_W-1:0]  cnt;
  logic [FRAC_W-1:0] acc;

  logic [FRAC_W:0]   acc_sum;
  logic [INT_W-1:0]  len_m1;
  logic              boundary;
  logic              legal;

  assign acc_sum  = {1'b0, acc} + {1'b0, div_frac};
  assign len_m1   = div_int + INT_W'(acc_sum[FRAC_W]) - INT_W'(1);
  assign tick     = running && (cnt == '0);
  assign boundary = !running || tick;
  assign legal    = (div_int != '0);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      running <= 1'b0;
      cnt     <= '0;
      acc     <= '0;
    end else if (boundary) begin
      if (legal) begin
        running <= 1'b1;
        cnt     <= len_m1;
        acc     <= acc_sum[FRAC_W-1:0];
      end else begin
        running <= 1'b0;
        cnt     <= '0;
        acc     <= '0;
      end
    end else begin
      cnt <= cnt - INT_W'(1);
    end
  end

  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !tick);

  p_zero_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_int == '0) |=> !tick);

  p_every_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && en && div_int == INT_W'(1) && div_frac == '0) |=> tick);

  p_no_truncate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !tick && en) |=> (cnt == $past(cnt) - INT_W'(1)));

  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && en && div_int > INT_W'(1)) |=> !tick);

  p_no_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && en && div_frac == '0) |=> $stable(acc));

endmodule

// File: tb/frac_baud_gen_tb.sv
module frac_baud_gen_tb;
  localparam int INT_W  = 4;
  localparam int FRAC_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [INT_W-1:0]  div_int = '0;
  logic [FRAC_W-1:0] div_frac = '0;
  logic tick;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  frac_baud_gen #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en),
    .div_int(div_int), .div_frac(div_frac), .tick(tick)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      errors = errors + 1;
      $display("FAIL R3 watchdog expired actual=%0d expected<=190000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_tick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n = n + 1;
    end while (!tick && n < 200);
  endtask

  function automatic int exp_len(input int i, input int f, input int n);
    return i + (n * f) / 64 - ((n - 1) * f) / 64;
  endfunction

  task automatic run_cfg(input int i, input int f, input string req);
    int n;
    int sum;
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    div_int  = INT_W'(i);
    div_frac = FRAC_W'(f);
    en = 1'b1;
    if (!tick) wait_tick(n);
    sum = 0;
    for (int k = 2; k <= 65; k++) begin
      wait_tick(n);
      sum = sum + n;
      check(n == exp_len(i, f, k), "R4 interval", n, exp_len(i, f, k));
      if (f == 0) check(n == i, "R2 whole divisor", n, i);
    end
    check(sum == 64 * i + f, req, sum, 64 * i + f);
  endtask

  initial begin
    int n;
    int cnt;
    repeat (3) begin
      @(negedge clk);
      check(tick == 1'b0, "R1 in reset", int'(tick), 0);
    end
    rst_n = 1'b1;
    repeat (5) begin
      @(negedge clk);
      check(tick == 1'b0, "R1 disabled", int'(tick), 0);
    end

    // R3 R4 sweep
    for (int i = 1; i <= 4; i++)
      for (int f = 0; f < 64; f++)
        run_cfg(i, f, "R3 64-period sum");
    run_cfg(15, 0, "R3 top int");
    run_cfg(15, 1, "R3 top int");
    run_cfg(15, 31, "R3 top int");
    run_cfg(15, 63, "R3 top int");

    // R10 worked example
    run_cfg(1, 5, "R10 example sum");

    // R5 every cycle
    @(negedge clk); en = 1'b0;
    @(negedge clk); div_int = 4'd1; div_frac = '0; en = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      check(tick == 1'b1, "R5 every cycle", int'(tick), 1);
    end

    // R7 enable drop
    en = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      check(tick == 1'b0, "R7 disabled", int'(tick), 0);
    end

    // R9 single pulse
    div_int = 4'd3; div_frac = '0; en = 1'b1;
    wait_tick(n);
    @(negedge clk);
    check(tick == 1'b0, "R9 single pulse", int'(tick), 0);
    @(negedge clk);
    check(tick == 1'b0, "R9 single pulse", int'(tick), 0);
    @(negedge clk);
    check(tick == 1'b1, "R9 period end", int'(tick), 1);

    // R8 mid-period change
    @(negedge clk);
    div_int = 4'd7;
    wait_tick(n);
    check(n == 2, "R8 current period kept", n + 1, 3);
    wait_tick(n);
    check(n == 7, "R8 new divisor", n, 7);

    // R6 zero mid-period then idle
    @(negedge clk);
    div_int = 4'd0;
    cnt = 0;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      if (tick) cnt = cnt + 1;
    end
    check(cnt == 1, "R6 zero integer", cnt, 1);

    // R6 zero from idle
    en = 1'b0;
    @(negedge clk);
    div_frac = 6'd5; en = 1'b1;
    cnt = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (tick) cnt = cnt + 1;
    end
    check(cnt == 0, "R6 zero from idle", cnt, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule